// File: doc/BRIEF.md
# Tagged Transmit Byte Queue with Empty-Space Threshold

This block is the staging queue between a host register port and a serial bit-oriented frame transmitter. The host pushes data bytes one at a time, and a separate control strobe marks frame boundaries by setting a frame-end tag or an abort tag. Each stored byte carries these two tag bits. The transmitter side sees the oldest byte and its tags at all times and removes it with a pop strobe.

The queue holds 64 entries by default, and the depth must be a power of two. It reports how many more bytes can be accepted. That count is compared against a 6-bit host-programmed level to produce a live "room available" flag and a sticky interrupt bit, which the host clears by a status-read strobe. A push into a full queue is not refused and raises no error. It replaces the newest stored byte, so a host that overruns the queue loses data.

An asynchronous active-low reset is released synchronously inside the block. A synchronous flush input empties the queue and clears every tag.

Top module: `tx_byte_queue`

## Requirements
- R1: Two clock edges after reset release, and on the edge of a flush, the queue is empty: `empty_slots` = 64 and `rd_avail` = 0. `rd_avail` is 1 exactly when `empty_slots` differs from 64.
- R2: Bytes leave in the order they were written. `rd_data` shows the oldest byte without delay, and `rd_en` removes it at the clock edge.
- R3: `empty_slots` equals 64 minus the number of stored bytes and changes just after the edge on which a push or pop takes effect.
- R4: `room_flag` is 1 exactly when `empty_slots` >= `empty_level` (unsigned), with no register delay.
- R5: `room_irq` is set on the edge after any cycle in which `room_flag` is 1. It stays set until an edge on which `stat_rd` is 1 while `room_flag` is 0, and then it clears. A `stat_rd` while `room_flag` is 1 leaves it set.
- R6: A write while the queue is full and no pop is requested replaces the data of the newest byte. The count stays full and the older bytes are unchanged.
- R7: A control write (`tag_we`) ORs `tag_done` and `tag_abort` into the newest byte. If a byte is written in the same cycle, the tags go to that byte. The tags reach the output as `rd_done` (bit 1 of the tag pair) and `rd_abort` (bit 0) together with their byte.
- R8: Once set on a byte, the frame-end tag cannot be cleared by a later control write.
- R9: A pop on an empty queue is ignored. The count stays 64, `rd_avail` stays 0, and the next written byte is the next one read.
- R10: A flush discards all bytes and tags. A byte written after it reads back with both tags 0.
- R11: A write and a pop in the same cycle on a full queue act as an ordinary push and pop. The count stays 0 empty slots, and the new byte is placed behind the rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of queue and tags |
| wr_en | input | 1 | Push `wr_data` |
| wr_data | input | 8 | Byte to store |
| tag_we | input | 1 | Control write of tags onto newest byte |
| tag_done | input | 1 | Frame-end tag value for control write |
| tag_abort | input | 1 | Abort tag value for control write |
| empty_level | input | 6 | Programmed empty-space threshold |
| stat_rd | input | 1 | Host status read, clears the sticky interrupt |
| rd_en | input | 1 | Pop oldest byte |
| rd_data | output | 8 | Oldest byte |
| rd_done | output | 1 | Frame-end tag of oldest byte |
| rd_abort | output | 1 | Abort tag of oldest byte |
| rd_avail | output | 1 | Queue not empty |
| empty_slots | output | 7 | Number of free locations |
| room_flag | output | 1 | Live threshold flag |
| room_irq | output | 1 | Sticky threshold interrupt |

## Verification
Pushes, pops, flushes and control writes act on the edge where they are sampled. `empty_slots`, `room_flag`, `rd_data` and the output tags therefore settle just after that same edge. `room_irq` follows one edge later, because it registers the flag. Inputs are driven on the falling edge, and every result is read on the next falling edge. The interrupt checks also read the level between the flag edge and the interrupt edge, to show the one-cycle gap.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef struct packed {
    logic done;
    logic abort;
  } tag_t;
endpackage

// File: rtl/txq_ptr.sv
module txq_ptr #(
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic                     tag_we,
  output logic                     push,
  output logic [$clog2(DEPTH)-1:0] wr_idx,
  output logic                     tag_ok,
  output logic [$clog2(DEPTH)-1:0] tag_idx,
  output logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic                     empty,
  output logic [$clog2(DEPTH):0]   empty_slots
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] wr_ptr_q, wr_ptr_d;
  logic [PW-1:0] rd_ptr_q, rd_ptr_d;
  logic [PW-1:0] used;
  logic [AW-1:0] last_idx;
  logic          full;
  logic          pop;

  always_comb begin
    used        = wr_ptr_q - rd_ptr_q;
    empty       = (used == '0);
    full        = (used == PW'(DEPTH));
    empty_slots = PW'(DEPTH) - used;
    last_idx    = wr_ptr_q[AW-1:0] - AW'(1);
    // a write to a full queue with no pop lands on the newest byte
    push        = wr_en & (~full | rd_en);
    pop         = rd_en & ~empty;
    wr_idx      = push ? wr_ptr_q[AW-1:0] : last_idx;
    tag_idx     = wr_en ? wr_idx : last_idx;
    tag_ok      = tag_we & (wr_en | ~empty);
    rd_idx      = rd_ptr_q[AW-1:0];
  end

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
    end else begin
      if (push) wr_ptr_d = wr_ptr_q + PW'(1);
      if (pop)  rd_ptr_d = rd_ptr_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end
endmodule

// File: rtl/txq_store.sv
module txq_store
  import txq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     wr_en,
  input  logic [DW-1:0]            wr_data,
  input  logic                     push,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic                     tag_ok,
  input  logic [$clog2(DEPTH)-1:0] tag_idx,
  input  logic                     tag_done,
  input  logic                     tag_abort,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [DW-1:0]            rd_data,
  output tag_t                     rd_tag
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0]    mem_q [DEPTH];
  logic [DEPTH-1:0] done_q, done_d;
  logic [DEPTH-1:0] abort_q, abort_d;

  // data array: no reset, written only under its enable
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_data;
  end

  // per-slot tag next state: fresh push clears, control write ORs in
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic fresh, hit;
    assign fresh      = push & (wr_idx == AW'(g));
    assign hit        = tag_ok & (tag_idx == AW'(g));
    assign done_d[g]  = ~flush & ((done_q[g]  & ~fresh) | (hit & tag_done));
    assign abort_d[g] = ~flush & ((abort_q[g] & ~fresh) | (hit & tag_abort));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= '0;
      abort_q <= '0;
    end else begin
      done_q  <= done_d;
      abort_q <= abort_d;
    end
  end

  always_comb begin
    rd_data      = mem_q[rd_idx];
    rd_tag.done  = done_q[rd_idx];
    rd_tag.abort = abort_q[rd_idx];
  end
endmodule

// File: rtl/txq_level.sv
module txq_level #(
  parameter int PW = 7,
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] empty_slots,
  input  logic [LW-1:0] level,
  input  logic          stat_rd,
  output logic          room_flag,
  output logic          room_irq
);
  localparam int MW = (PW > LW) ? PW : LW;

  logic [MW-1:0] slots_x, level_x;
  logic          irq_q, irq_d;

  always_comb begin
    slots_x   = MW'(empty_slots);
    level_x   = MW'(level);
    room_flag = (slots_x >= level_x);
    irq_d     = room_flag | (irq_q & ~stat_rd);
    room_irq  = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/tx_byte_queue.sv
module tx_byte_queue
  import txq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  parameter int LW    = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   wr_en,
  input  logic [DW-1:0]          wr_data,
  input  logic                   tag_we,
  input  logic                   tag_done,
  input  logic                   tag_abort,
  input  logic [LW-1:0]          empty_level,
  input  logic                   stat_rd,
  input  logic                   rd_en,
  output logic [DW-1:0]          rd_data,
  output logic                   rd_done,
  output logic                   rd_abort,
  output logic                   rd_avail,
  output logic [$clog2(DEPTH):0] empty_slots,
  output logic                   room_flag,
  output logic                   room_irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          rst_meta_q, rst_q_n;
  logic          push, tag_ok, empty;
  logic [AW-1:0] wr_idx, tag_idx, rd_idx;
  tag_t          rd_tag;

  // reset: asserted at once, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q_n    <= rst_meta_q;
    end
  end

  txq_ptr #(.DEPTH(DEPTH)) i_ptr (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .flush       (flush),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .tag_we      (tag_we),
    .push        (push),
    .wr_idx      (wr_idx),
    .tag_ok      (tag_ok),
    .tag_idx     (tag_idx),
    .rd_idx      (rd_idx),
    .empty       (empty),
    .empty_slots (empty_slots)
  );

  txq_store #(.DEPTH(DEPTH), .DW(DW)) i_store (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .flush     (flush),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .push      (push),
    .wr_idx    (wr_idx),
    .tag_ok    (tag_ok),
    .tag_idx   (tag_idx),
    .tag_done  (tag_done),
    .tag_abort (tag_abort),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .rd_tag    (rd_tag)
  );

  txq_level #(.PW(PW), .LW(LW)) i_level (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .empty_slots (empty_slots),
    .level       (empty_level),
    .stat_rd     (stat_rd),
    .room_flag   (room_flag),
    .room_irq    (room_irq)
  );

  assign rd_done  = rd_tag.done;
  assign rd_abort = rd_tag.abort;
  assign rd_avail = ~empty;
endmodule

// File: rtl/txq_chk.sv
module txq_chk #(
  parameter int DEPTH = 64
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   flush,
  input logic                   wr_en,
  input logic                   rd_en,
  input logic                   stat_rd,
  input logic                   rd_avail,
  input logic [$clog2(DEPTH):0] empty_slots,
  input logic                   room_flag,
  input logic                   room_irq
);
  localparam int CW = $clog2(DEPTH) + 1;

  // R3
  slots_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty_slots <= CW'(DEPTH));

  // R1
  avail_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_avail == (empty_slots != CW'(DEPTH)));

  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_avail && rd_en && !wr_en && !flush) |=> (empty_slots == CW'(DEPTH)));

  // R6
  full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_slots == '0 && wr_en && !rd_en && !flush) |=> (empty_slots == '0));

  // R11
  full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_slots == '0 && wr_en && rd_en && !flush) |=> (empty_slots == '0));

  // R5
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    room_flag |=> room_irq);

  // R5
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!room_flag && stat_rd) |=> !room_irq);

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty_slots == CW'(DEPTH)));
endmodule

bind tx_byte_queue txq_chk #(.DEPTH(DEPTH)) i_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .flush       (flush),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .stat_rd     (stat_rd),
  .rd_avail    (rd_avail),
  .empty_slots (empty_slots),
  .room_flag   (room_flag),
  .room_irq    (room_irq)
);

// File: tb/test_tx_byte_queue.sv
module test_tx_byte_queue;
  logic       clk, rst_n, flush, wr_en, tag_we, tag_done, tag_abort, stat_rd, rd_en;
  logic [7:0] wr_data, rd_data;
  logic [5:0] empty_level;
  logic       rd_done, rd_abort, rd_avail, room_flag, room_irq;
  logic [6:0] empty_slots;
  int         n_chk = 0;
  int         n_fail = 0;
  logic       finished = 1'b0;

  tx_byte_queue i_tx_byte_queue (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_data(wr_data),
    .tag_we(tag_we), .tag_done(tag_done), .tag_abort(tag_abort),
    .empty_level(empty_level), .stat_rd(stat_rd), .rd_en(rd_en),
    .rd_data(rd_data), .rd_done(rd_done), .rd_abort(rd_abort), .rd_avail(rd_avail),
    .empty_slots(empty_slots), .room_flag(room_flag), .room_irq(room_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge act, return at the next falling edge
  task automatic step(input logic w, input logic [7:0] d, input logic tw,
                      input logic td, input logic ta, input logic r,
                      input logic s, input logic f);
    wr_en = w; wr_data = d; tag_we = tw; tag_done = td; tag_abort = ta;
    rd_en = r; stat_rd = s; flush = f;
    @(negedge clk);
    wr_en = 0; tag_we = 0; tag_done = 0; tag_abort = 0; rd_en = 0; stat_rd = 0; flush = 0;
  endtask

  task automatic put(input logic [7:0] d);
    step(1, d, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic pop_chk(input string req, input int d, input int dn, input int ab);
    chk(req, int'(rd_data), d);
    chk(req, int'(rd_done), dn);
    chk(req, int'(rd_abort), ab);
    step(0, 8'h00, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_reset();
    chk("R1 slots", int'(empty_slots), 64);
    chk("R1 avail", int'(rd_avail), 0);
    chk("R4 flag at level 0", int'(room_flag), 1);
    chk("R5 irq after reset", int'(room_irq), 1);
  endtask

  task automatic t_order();
    put(8'd10); put(8'd20); put(8'd30); put(8'd40); put(8'd50);
    chk("R3 slots after 5", int'(empty_slots), 59);
    chk("R1 avail", int'(rd_avail), 1);
    for (int i = 1; i <= 5; i++) pop_chk("R2 order", i * 10, 0, 0);
    chk("R3 slots drained", int'(empty_slots), 64);
  endtask

  task automatic t_level();
    empty_level = 6'd60;
    for (int i = 0; i < 4; i++) put(8'(i));
    chk("R4 slots 60 level 60", int'(room_flag), 1);
    put(8'd4);
    chk("R4 slots 59 level 60", int'(room_flag), 0);
    chk("R5 irq sticky", int'(room_irq), 1);
    step(0, 8'h00, 0, 0, 0, 0, 1, 0);
    chk("R5 irq cleared by read", int'(room_irq), 0);
    step(0, 8'h00, 0, 0, 0, 1, 0, 0);
    chk("R4 flag after pop", int'(room_flag), 1);
    chk("R5 irq one edge later", int'(room_irq), 0);
    step(0, 8'h00, 0, 0, 0, 0, 0, 0);
    chk("R5 irq set", int'(room_irq), 1);
    step(0, 8'h00, 0, 0, 0, 0, 1, 0);
    chk("R5 read while flag holds", int'(room_irq), 1);
    for (int i = 0; i < 4; i++) step(0, 8'h00, 0, 0, 0, 1, 0, 0);
    empty_level = 6'd0;
  endtask

  task automatic t_tags();
    put(8'hA1);
    put(8'hB2);
    step(0, 8'h00, 1, 1, 0, 0, 0, 0);
    step(1, 8'hC3, 1, 0, 1, 0, 0, 0);
    put(8'hD4);
    step(0, 8'h00, 1, 1, 0, 0, 0, 0);
    step(0, 8'h00, 1, 0, 0, 0, 0, 0);
    pop_chk("R7 untagged", 8'hA1, 0, 0);
    pop_chk("R7 done on newest", 8'hB2, 1, 0);
    pop_chk("R7 abort same cycle", 8'hC3, 0, 1);
    pop_chk("R8 done kept", 8'hD4, 1, 0);
  endtask

  task automatic t_full();
    for (int i = 0; i < 64; i++) put(8'(i));
    chk("R3 full", int'(empty_slots), 0);
    put(8'hEE);
    chk("R6 still full", int'(empty_slots), 0);
    for (int i = 0; i < 63; i++) pop_chk("R6 older intact", i, 0, 0);
    pop_chk("R6 newest replaced", 8'hEE, 0, 0);
  endtask

  task automatic t_swap();
    for (int i = 0; i < 64; i++) put(8'(i));
    step(1, 8'h55, 0, 0, 0, 1, 0, 0);
    chk("R11 count held", int'(empty_slots), 0);
    for (int i = 1; i < 64; i++) pop_chk("R11 order", i, 0, 0);
    pop_chk("R11 tail", 8'h55, 0, 0);
  endtask

  task automatic t_empty_pop();
    for (int i = 0; i < 3; i++) step(0, 8'h00, 0, 0, 0, 1, 0, 0);
    chk("R9 slots", int'(empty_slots), 64);
    chk("R9 avail", int'(rd_avail), 0);
    put(8'h11);
    chk("R9 slots after write", int'(empty_slots), 63);
    pop_chk("R9 next byte", 8'h11, 0, 0);
  endtask

  task automatic t_flush();
    put(8'h21);
    step(1, 8'h22, 1, 1, 1, 0, 0, 0);
    step(0, 8'h00, 0, 0, 0, 0, 0, 1);
    chk("R10 slots", int'(empty_slots), 64);
    chk("R10 avail", int'(rd_avail), 0);
    put(8'h77);
    pop_chk("R10 clean byte", 8'h77, 0, 0);
  endtask

  initial begin
    rst_n = 0; flush = 0; wr_en = 0; wr_data = 0; tag_we = 0; tag_done = 0;
    tag_abort = 0; stat_rd = 0; rd_en = 0; empty_level = 6'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_order();
    t_level();
    t_tags();
    t_full();
    t_swap();
    t_empty_pop();
    t_flush();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule